// File: doc/BRIEF.md
# SIMD Byte-Load Lane Placement Unit

This unit executes a single byte-load instruction on behalf of a 32-bit SIMD register file. It takes a 32-bit instruction word over a valid/ready issue port, pulls out a destination SIMD register number, a base general-purpose register number, a signed 8-bit displacement and a 3-bit placement code. It reads the base register through a GPR read port and adds the sign-extended displacement to form a byte address. It then fetches one byte over a valid/ready memory request port and writes a placed 32-bit result into the destination SIMD register.

Placement codes 0 to 3 merge the byte into one lane of the destination's current value, which is read through the SIMD read port. Codes 4 to 7 build the whole word from the byte alone, using zero-interleaved, sign-interleaved or fully replicated patterns. A plain enable input, taken from the SIMD control register, gates the whole operation. When it is low at issue, the instruction retires at once with no memory traffic and no register write.

Back-pressure rules: an instruction is taken only on a cycle where `issue_valid` and `issue_ready` are both high, and `issue_ready` is high only while the unit is idle. Once `mem_req_valid` rises, it stays high with a stable `mem_req_addr` until a cycle with `mem_req_ready` high. The memory must return the byte with `mem_rsp_valid` no earlier than the cycle after that handshake. The unit has no response ready, because it always takes the response while waiting.

Top module: `sbl_unit`

## Requirements
- R1: Instruction bits 9:6 name the destination SIMD register (`vr_waddr`, `vr_raddr`), bits 17:10 hold the signed displacement, bits 20:18 the placement code, and bits 25:21 the base GPR (`gpr_raddr`, driven from `issue_instr` while idle). All other bits are ignored.
- R2: `mem_req_addr` equals the base GPR value plus the displacement sign-extended to 32 bits, with 32-bit wraparound.
- R3: If `ctl_enable` is low on the issue handshake, `done` pulses in the next cycle, and neither `mem_req_valid` nor `vr_we` is asserted for that instruction.
- R4: Codes 0, 1, 2 and 3 write the byte into bits 7:0, 15:8, 23:16 and 31:24 respectively. The other three bytes keep the destination's prior value.
- R5: Code 4 writes {8'h00, b, 8'h00, b} and code 5 writes {b, 8'h00, b, 8'h00}.
- R6: Code 6 writes {{8{b[7]}}, b, {8{b[7]}}, b}.
- R7: Code 7 writes {b, b, b, b}.
- R8: For codes 4 to 7 the written word does not depend on the destination's prior value.
- R9: `issue_ready` is high only when idle. `busy` is high from the cycle the memory request is raised through the write cycle. `vr_we` and `done` are high together for exactly one cycle, the cycle after the memory response.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with an unchanged address in the next cycle.
- R11: A synchronous active-high `rst` returns the unit to idle, with `mem_req_valid`, `vr_we`, `busy` and `done` low and `issue_ready` high, even in the middle of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Enable bit from the SIMD control register |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Unit idle and able to take an instruction |
| issue_instr | input | 32 | Instruction word |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| gpr_raddr | output | 5 | GPR read index |
| gpr_rdata | input | 32 | GPR read data (combinational) |
| vr_raddr | output | 4 | SIMD register read index |
| vr_rdata | input | 32 | SIMD register read data (combinational) |
| vr_we | output | 1 | SIMD register write enable |
| vr_waddr | output | 4 | SIMD register write index |
| vr_wdata | output | 32 | SIMD register write data |
| mem_req_valid | output | 1 | Byte read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Byte address |
| mem_rsp_valid | input | 1 | Read byte valid |
| mem_rsp_data | input | 8 | Read byte |

## Verification
The bench builds the unit with its default widths: a 32-bit word of four 8-bit lanes, 16 SIMD registers and 32 GPRs. At these widths the lane patterns of codes 4 to 7 are fully distinct. Every destination index, from 0 to 15, and base indices up to 31 can be reached. The displacement's sign extension can be driven across a 16-bit borrow. The vector table spreads memory stalls of zero to three cycles over all eight codes, so the hold rule is seen under back-pressure for several placements.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  localparam int WORD_W    = 32;
  localparam int LANE_W    = 8;
  localparam int LANES     = WORD_W / LANE_W;
  localparam int XR_IDX_W  = 4;
  localparam int GPR_IDX_W = 5;
  localparam int OPT_W     = 3;
  localparam int OFF_W     = 8;
  // Field positions decoded from the instruction word
  localparam int XR_LSB    = 6;
  localparam int OFF_LSB   = XR_LSB + XR_IDX_W;
  localparam int OPT_LSB   = OFF_LSB + OFF_W;
  localparam int GPR_LSB   = OPT_LSB + OPT_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SKIP, ST_REQ, ST_WAIT, ST_WR
  } sbl_state_t;

  typedef struct packed {
    logic [GPR_IDX_W-1:0] base;
    logic [OPT_W-1:0]     opt;
    logic [OFF_W-1:0]     off;
    logic [XR_IDX_W-1:0]  dst;
  } sbl_fields_t;
endpackage

// File: rtl/sbl_decode.sv
module sbl_decode
  import sbl_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output sbl_fields_t       fields
);
  logic unused_bits;
  assign unused_bits = ^{instr[WORD_W-1:GPR_LSB+GPR_IDX_W], instr[XR_LSB-1:0]};

  assign fields.base = instr[GPR_LSB +: GPR_IDX_W];
  assign fields.opt  = instr[OPT_LSB +: OPT_W];
  assign fields.off  = instr[OFF_LSB +: OFF_W];
  assign fields.dst  = instr[XR_LSB  +: XR_IDX_W];
endmodule

// File: rtl/sbl_agen.sv
module sbl_agen #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] addr
);
  localparam int EXT_W = ADDR_W - DISP_W;
  logic [ADDR_W-1:0] disp_ext;
  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign addr     = base + disp_ext;
endmodule

// File: rtl/sbl_place.sv
module sbl_place #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  parameter int OPT_W  = 3
) (
  input  logic [OPT_W-1:0]        opt,
  input  logic [LANE_W-1:0]       byte_in,
  input  logic [LANES*LANE_W-1:0] old_word,
  output logic [LANES*LANE_W-1:0] new_word
);
  localparam logic [OPT_W-1:0] PAT_BASE = OPT_W'(LANES);

  logic [OPT_W-1:0]  pat;
  logic [LANE_W-1:0] sext;
  assign pat  = opt - PAT_BASE;
  assign sext = {LANE_W{byte_in[LANE_W-1]}};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OPT_W-1:0] MY_CODE = OPT_W'(i);
    localparam bit               EVEN    = (i % 2) == 0;
    logic [LANE_W-1:0] lane;
    always_comb begin
      if (opt < PAT_BASE) begin
        lane = (opt == MY_CODE) ? byte_in : old_word[i*LANE_W +: LANE_W];
      end else begin
        case (pat)
          OPT_W'(0): lane = EVEN ? byte_in : '0;
          OPT_W'(1): lane = EVEN ? '0 : byte_in;
          OPT_W'(2): lane = EVEN ? byte_in : sext;
          default:   lane = byte_in;
        endcase
      end
    end
    assign new_word[i*LANE_W +: LANE_W] = lane;
  end
endmodule

// File: rtl/sbl_unit.sv
module sbl_unit
  import sbl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_enable,
  input  logic                 issue_valid,
  output logic                 issue_ready,
  input  logic [WORD_W-1:0]    issue_instr,
  output logic                 busy,
  output logic                 done,
  output logic [GPR_IDX_W-1:0] gpr_raddr,
  input  logic [WORD_W-1:0]    gpr_rdata,
  output logic [XR_IDX_W-1:0]  vr_raddr,
  input  logic [WORD_W-1:0]    vr_rdata,
  output logic                 vr_we,
  output logic [XR_IDX_W-1:0]  vr_waddr,
  output logic [WORD_W-1:0]    vr_wdata,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [WORD_W-1:0]    mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [LANE_W-1:0]    mem_rsp_data
);
  sbl_state_t        state_q;
  sbl_fields_t       fin;
  logic [WORD_W-1:0] ea;
  logic [WORD_W-1:0] addr_q;
  logic [XR_IDX_W-1:0] dst_q;
  logic [OPT_W-1:0]  opt_q;
  logic [LANE_W-1:0] byte_q;
  logic              accept;

  sbl_decode u_dec (.instr(issue_instr), .fields(fin));

  sbl_agen #(.ADDR_W(WORD_W), .DISP_W(OFF_W)) u_agen (
    .base(gpr_rdata), .disp(fin.off), .addr(ea)
  );

  sbl_place #(.LANE_W(LANE_W), .LANES(LANES), .OPT_W(OPT_W)) u_place (
    .opt(opt_q), .byte_in(byte_q), .old_word(vr_rdata), .new_word(vr_wdata)
  );

  assign issue_ready   = (state_q == ST_IDLE);
  assign accept        = issue_valid && issue_ready;
  assign gpr_raddr     = fin.base;
  assign vr_raddr      = dst_q;
  assign vr_waddr      = dst_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_valid = (state_q == ST_REQ);
  assign vr_we         = (state_q == ST_WR);
  assign done          = (state_q == ST_WR) || (state_q == ST_SKIP);
  assign busy          = (state_q == ST_REQ) || (state_q == ST_WAIT) || (state_q == ST_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      dst_q   <= '0;
      opt_q   <= '0;
      byte_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= ea;
          dst_q   <= fin.dst;
          opt_q   <= fin.opt;
          state_q <= ctl_enable ? ST_REQ : ST_SKIP;
        end
        ST_SKIP: state_q <= ST_IDLE;
        ST_REQ:  if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          byte_q  <= mem_rsp_data;
          state_q <= ST_WR;
        end
        ST_WR:   state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: request held under back-pressure
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: write only together with completion while busy
  assert_write_done_R9: assert property (@(posedge clk) disable iff (rst)
    vr_we |-> (done && busy));

  // R3: disabled issue retires next cycle without traffic
  assert_skip_R3: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_ready && !ctl_enable) |=> (done && !vr_we && !mem_req_valid));

  // R11: reset leaves no request and no write pending
  assert_reset_idle_R11: assert property (@(posedge clk)
    rst |=> (!mem_req_valid && !vr_we && !busy && issue_ready));
endmodule

// File: tb/sim_sbl_unit.sv
module sim_sbl_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {opt, disp, dst, base, stall, pad}
  localparam logic [23:0] VEC [NVEC] = '{
    {3'd0, 8'h10, 4'd3,  5'd1,  2'd0, 2'd0},
    {3'd1, 8'h45, 4'd3,  5'd2,  2'd1, 2'd0},
    {3'd2, 8'hF0, 4'd5,  5'd4,  2'd0, 2'd0},
    {3'd3, 8'h80, 4'd5,  5'd7,  2'd2, 2'd0},
    {3'd4, 8'h45, 4'd0,  5'd9,  2'd0, 2'd0},
    {3'd5, 8'h10, 4'd15, 5'd31, 2'd1, 2'd0},
    {3'd6, 8'h45, 4'd8,  5'd3,  2'd0, 2'd0},
    {3'd6, 8'h10, 4'd8,  5'd3,  2'd0, 2'd0},
    {3'd7, 8'h7F, 4'd12, 5'd0,  2'd3, 2'd0},
    {3'd0, 8'h81, 4'd12, 5'd6,  2'd0, 2'd0},
    {3'd3, 8'h00, 4'd15, 5'd5,  2'd0, 2'd0},
    {3'd5, 8'hFF, 4'd1,  5'd17, 2'd2, 2'd0}
  };

  logic clk = 0, rst = 1, ctl_enable = 1, issue_valid = 0;
  logic [31:0] issue_instr = '0;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic [7:0] mem_rsp_data = '0;
  logic issue_ready, busy, done, vr_we, mem_req_valid;
  logic [4:0] gpr_raddr;
  logic [3:0] vr_raddr, vr_waddr;
  logic [31:0] gpr_rdata, vr_rdata, vr_wdata, mem_req_addr;

  logic [31:0] gpr [32];
  logic [31:0] xr [16];
  int total = 0, bad = 0;
  bit finished = 0;

  assign gpr_rdata = gpr[gpr_raddr];
  assign vr_rdata  = xr[vr_raddr];

  always #(CLK_PERIOD/2) clk = ~clk;

  sbl_unit u0 (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic [2:0] opt, input logic [7:0] b, input logic [31:0] old);
    logic [31:0] w;
    w = old;
    case (opt)
      3'd0: w[7:0]   = b;
      3'd1: w[15:8]  = b;
      3'd2: w[23:16] = b;
      3'd3: w[31:24] = b;
      3'd4: w = {8'h00, b, 8'h00, b};
      3'd5: w = {b, 8'h00, b, 8'h00};
      3'd6: w = {{8{b[7]}}, b, {8{b[7]}}, b};
      default: w = {b, b, b, b};
    endcase
    return w;
  endfunction

  function automatic string opt_req(input logic [2:0] opt);
    if (opt < 3'd4) return "R4";
    if (opt < 3'd6) return "R5";
    if (opt == 3'd6) return "R6";
    return "R7";
  endfunction

  // Runs one enabled load; memory returns the low address byte. Returns written word.
  task automatic run_load(input logic [2:0] opt, input logic [7:0] disp, input logic [3:0] dst,
                          input logic [4:0] base, input int stall, output logic [31:0] got);
    logic [31:0] exp_addr, exp_word;
    exp_addr = gpr[base] + {{24{disp[7]}}, disp};
    @(negedge clk);
    issue_instr = {6'h2A, base, opt, disp, dst, 6'h15};
    issue_valid = 1;
    check(issue_ready == 1, "R9 ready when idle", 32'(issue_ready), 1);
    check(gpr_raddr == base, "R1 base field", 32'(gpr_raddr), 32'(base));
    @(negedge clk);
    issue_valid = 0;
    check(mem_req_valid && busy && !issue_ready, "R9 request/busy", {busy, issue_ready, mem_req_valid}, 3'b101);
    check(mem_req_addr == exp_addr, "R2 address", mem_req_addr, exp_addr);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(mem_req_valid && mem_req_addr == exp_addr, "R10 hold", mem_req_addr, exp_addr);
    end
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0;
    check(!mem_req_valid && !done && busy, "R9 waiting", {busy, done, mem_req_valid}, 3'b100);
    mem_rsp_valid = 1;
    mem_rsp_data  = exp_addr[7:0];
    exp_word = expect_word(opt, exp_addr[7:0], xr[dst]);
    @(negedge clk);
    mem_rsp_valid = 0;
    check(vr_we && done, "R9 write with done", {vr_we, done}, 2'b11);
    check(vr_waddr == dst, "R1 dst field", 32'(vr_waddr), 32'(dst));
    check(vr_wdata == exp_word, opt_req(opt), vr_wdata, exp_word);
    got = vr_wdata;
    if (vr_we) xr[vr_waddr] = vr_wdata;
    @(negedge clk);
    check(!done && !busy && !vr_we, "R9 single pulse", {done, busy, vr_we}, 0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r1, r2;
    for (int i = 0; i < 32; i++) gpr[i] = 32'h1000_0040 + (i << 16);
    for (int i = 0; i < 16; i++) xr[i] = 32'h8000_0000 ^ (i * 32'h1357_9BDF);
    repeat (3) @(negedge clk);
    check(!mem_req_valid && !vr_we && !busy && !done && issue_ready, "R11 reset state",
          {mem_req_valid, vr_we, busy, done, issue_ready}, 5'b00001);
    rst = 0;

    foreach (VEC[k]) begin
      run_load(VEC[k][23:21], VEC[k][20:13], VEC[k][12:9], VEC[k][8:4], int'(VEC[k][3:2]), r1);
    end

    // R8: patterns ignore previous destination contents
    for (int o = 4; o < 8; o++) begin
      xr[2] = 32'h1234_5678;
      run_load(3'(o), 8'h45, 4'd2, 5'd1, 0, r1);
      xr[2] = 32'hFFFF_FFFF;
      run_load(3'(o), 8'h45, 4'd2, 5'd1, 0, r2);
      check(r1 == r2, "R8 old-value independence", r2, r1);
    end

    // R3: disabled instruction retires without traffic
    r1 = xr[6];
    @(negedge clk);
    ctl_enable = 0;
    issue_instr = {6'h0, 5'd3, 3'd7, 8'h01, 4'd6, 6'h0};
    issue_valid = 1;
    @(negedge clk);
    issue_valid = 0;
    check(done && !mem_req_valid && !vr_we && !busy, "R3 skip",
          {done, mem_req_valid, vr_we, busy}, 4'b1000);
    @(negedge clk);
    check(!done && issue_ready && !mem_req_valid, "R3 back to idle", {done, issue_ready}, 2'b01);
    ctl_enable = 1;
    run_load(3'd0, 8'h00, 4'd6, 5'd0, 0, r2);
    check(r2[31:8] == r1[31:8], "R3 destination untouched", r2, r1);

    // R11: reset in the middle of a request
    @(negedge clk);
    issue_instr = {6'h0, 5'd2, 3'd7, 8'h01, 4'd4, 6'h0};
    issue_valid = 1;
    @(negedge clk);
    issue_valid = 0;
    rst = 1;
    @(negedge clk);
    check(!mem_req_valid && !busy && !vr_we && issue_ready, "R11 mid-op reset",
          {mem_req_valid, busy, vr_we, issue_ready}, 4'b0001);
    rst = 0;
    @(negedge clk);
    check(!mem_req_valid && !done, "R11 stays idle", {mem_req_valid, done}, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule